// File: doc/BRIEF.md
# Banked Word RAM Array

This block is a word-addressed memory of 10240 sixteen-bit words, assembled from ten identical storage banks of 1024 words each. A 16-bit word address is split into a bank number in the upper field and a word offset in the lower ten bits. A 4-to-16 one-hot decoder turns the bank number into bank enables. Only the enabled bank stores write data or captures a read word. An AND-OR multiplexer returns the captured word of the bank that was read.

Only the low four bits of the six-bit bank field reach the decoder. The two top address bits are ignored, so addresses that differ only in those bits reach the same word. Decoder lines 10 to 15 enable no bank. An access that decodes to one of them writes nothing and reads back zero. Writes take effect on the rising clock edge. Read data is registered and appears one cycle after the read enable is sampled.

Top module: `banked_ram_array`

## Requirements
- R1: Address bits 13:10 give the bank number and bits 9:0 give the word offset, so bank b offset o is word b*1024+o. Address 3079 (bank 3, offset 7) and address 7 (bank 0, offset 7) are distinct words.
- R2: A write with `wr_en` high stores `wr_data` only in the addressed word of the addressed bank. The same offset in every other bank keeps its contents.
- R3: In every cycle at most one bank enable is active, and exactly one is active when the bank number is 0 to 9.
- R4: Read data is registered. After a read is sampled at a clock edge, `rd_data` shows the addressed word from that edge on, and it does not change before that edge.
- R5: Address bits 15:14 have no effect. An address with those bits set reads and writes the same word as the same address with those bits cleared.
- R6: A write whose bank number is 10 to 15 changes no stored word, and no bank enable is active for such an address.
- R7: A read whose bank number is 10 to 15 returns 16'h0000 on `rd_data` in the following cycle.
- R8: When `wr_en` and `rd_en` are both high in one cycle, the write is stored and the read returns the word's contents from before that write.
- R9: While `rd_en` is low, `rd_data` keeps its last value, whatever the address or write activity.
- R10: After reset, `rd_data` is 16'h0000.
- R11: The first and last word of a bank (offsets 0 and 1023) and the last word of the array (address 10239) are stored and read back like any other word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read path |
| addr | input | 16 | Word address: bank number and word offset |
| wr_en | input | 1 | Store `wr_data` at `addr` on this edge |
| rd_en | input | 1 | Capture the word at `addr` on this edge |
| wr_data | input | 16 | Word to store |
| rd_data | output | 16 | Registered read word |

## Verification
Four rules are checked by assertions on every cycle: at most one bank enable is active, exactly one is active for a mapped bank number, an unmapped number activates none and reads back zero, and `rd_data` holds while no read is sampled. The bench scenarios show what the assertions cannot: where words land, that neighbouring banks at the same offset are untouched, the aliasing of the top address bits, the old-data result of a read and write in the same cycle, the exact cycle at which read data changes, and the extreme words of the address space.

// File: rtl/bank_array_pkg.sv
package bank_array_pkg;

    parameter int unsigned DEF_ADDR_W     = 16;
    parameter int unsigned DEF_DATA_W     = 16;
    parameter int unsigned DEF_NUM_BANKS  = 10;
    parameter int unsigned DEF_BANK_WORDS = 1024;

    // Width of the bank number that feeds the decoder (never below one bit).
    function automatic int unsigned sel_width(input int unsigned n_banks);
        return (n_banks <= 2) ? 1 : $clog2(n_banks);
    endfunction

endpackage

// File: rtl/bank_cs_decoder.sv
module bank_cs_decoder #(
    parameter int unsigned SEL_W = 4,
    localparam int unsigned OUT_N = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [OUT_N-1:0] line
);

    for (genvar g = 0; g < OUT_N; g++) begin : g_line
        assign line[g] = (sel == SEL_W'(g));
    end

endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 1024,
    localparam int unsigned OFF_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_word_d, rd_word_q;

    // Storage array: written only when this bank is enabled.
    always_ff @(posedge clk) begin
        if (cs && wr_en) begin
            mem[offset] <= wr_data;
        end
    end

    // Read capture: samples the pre-write contents on the same edge.
    always_comb begin
        rd_word_d = rd_word_q;
        if (cs && rd_en) begin
            rd_word_d = mem[offset];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_word_q <= '0;
        end else begin
            rd_word_q <= rd_word_d;
        end
    end

    assign rd_word = rd_word_q;

endmodule

// File: rtl/bank_read_mux.sv
module bank_read_mux #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned NUM_BANKS = 10,
    parameter int unsigned SEL_W     = 4
) (
    input  logic [NUM_BANKS-1:0][DATA_W-1:0] words,
    input  logic [SEL_W-1:0]                 idx,
    input  logic                             hit,
    output logic [DATA_W-1:0]                word_out
);

    // AND-OR selection; a miss yields zero.
    always_comb begin
        word_out = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (hit && (idx == SEL_W'(i))) begin
                word_out = word_out | words[i];
            end
        end
    end

endmodule

// File: rtl/banked_ram_array.sv
module banked_ram_array
    import bank_array_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter int unsigned NUM_BANKS  = DEF_NUM_BANKS,
    parameter int unsigned BANK_WORDS = DEF_BANK_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data
);

    localparam int unsigned OFF_W = $clog2(BANK_WORDS);
    localparam int unsigned SEL_W = sel_width(NUM_BANKS);
    localparam int unsigned DEC_N = 1 << SEL_W;

    typedef struct packed {
        logic [SEL_W-1:0] idx;
        logic             hit;
    } rd_track_t;

    logic [OFF_W-1:0]                  offset;
    logic [SEL_W-1:0]                  bank_sel;
    logic [DEC_N-1:0]                  dec_lines;
    logic [NUM_BANKS-1:0]              bank_cs;
    logic                              unmapped;
    logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_words;
    rd_track_t                         trk_d, trk_q;

    assign offset   = addr[OFF_W-1:0];
    assign bank_sel = addr[OFF_W +: SEL_W];

    // Address bits above the decoded field reach no bank.
    if (ADDR_W > OFF_W + SEL_W) begin : g_hi
        logic unused_hi_bits;
        assign unused_hi_bits = ^addr[ADDR_W-1:OFF_W+SEL_W];
    end

    bank_cs_decoder #(
        .SEL_W (SEL_W)
    ) u_decoder (
        .sel  (bank_sel),
        .line (dec_lines)
    );

    assign bank_cs = dec_lines[NUM_BANKS-1:0];

    // Lines beyond the last bank mark an access that selects nothing.
    if (DEC_N > NUM_BANKS) begin : g_spare
        assign unmapped = |dec_lines[DEC_N-1:NUM_BANKS];
    end else begin : g_full
        assign unmapped = 1'b0;
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        ram_bank #(
            .DATA_W (DATA_W),
            .DEPTH  (BANK_WORDS)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .cs      (bank_cs[g]),
            .wr_en   (wr_en),
            .rd_en   (rd_en),
            .offset  (offset),
            .wr_data (wr_data),
            .rd_word (bank_words[g])
        );
    end

    // Remember which bank the last read went to, and whether it hit one.
    always_comb begin
        trk_d = trk_q;
        if (rd_en) begin
            trk_d.idx = bank_sel;
            trk_d.hit = ~unmapped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    bank_read_mux #(
        .DATA_W    (DATA_W),
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W)
    ) u_rd_mux (
        .words    (bank_words),
        .idx      (trk_q.idx),
        .hit      (trk_q.hit),
        .word_out (rd_data)
    );

endmodule

// File: rtl/bank_array_checker.sv
module bank_array_checker #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned NUM_BANKS = 10,
    parameter int unsigned OFF_W     = 10,
    parameter int unsigned SEL_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    addr,
    input logic                 rd_en,
    input logic [DATA_W-1:0]    rd_data,
    input logic [NUM_BANKS-1:0] bank_cs
);

    logic [SEL_W:0] field_ext;
    logic           mapped;

    assign field_ext = {1'b0, addr[OFF_W +: SEL_W]};
    assign mapped    = (field_ext < (SEL_W+1)'(NUM_BANKS));

    assert_cs_onehot0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_cs));

    assert_mapped_single_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mapped |-> ($countones(bank_cs) == 1));

    assert_unmapped_no_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bank_cs == '0));

    assert_unmapped_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> (rd_data == '0));

    assert_hold_without_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind banked_ram_array bank_array_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS),
    .OFF_W     (OFF_W),
    .SEL_W     (SEL_W)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .bank_cs (bank_cs)
);

// File: tb/tb_banked_ram_array.sv
module tb_banked_ram_array;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    banked_ram_array dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    function automatic logic [15:0] waddr(input int bank, input int off);
        return 16'(bank * 1024 + off);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_expect(input string req, input logic [15:0] a, input logic [15:0] exp);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, exp);
    endtask

    task automatic test_reset();
        check("R10 reset value", rd_data, 16'h0000);
    endtask

    task automatic test_split();
        write_word(16'd7, 16'h0007);
        write_word(waddr(2, 7), 16'h2222);
        write_word(waddr(4, 7), 16'h4444);
        write_word(16'd3079, 16'hC3D7);
        read_expect("R1 word 3079", 16'd3079, 16'hC3D7);
        read_expect("R1 bank3 off7 composed", waddr(3, 7), 16'hC3D7);
        read_expect("R1 word 7 distinct", 16'd7, 16'h0007);
        read_expect("R2 R3 bank2 untouched", waddr(2, 7), 16'h2222);
        read_expect("R2 R3 bank4 untouched", waddr(4, 7), 16'h4444);
    endtask

    task automatic test_edges();
        write_word(16'd0,     16'hA000);
        write_word(16'd1023,  16'hA3FF);
        write_word(16'd1024,  16'hB400);
        write_word(16'd10239, 16'h9FFF);
        read_expect("R11 word 0",     16'd0,     16'hA000);
        read_expect("R11 word 1023",  16'd1023,  16'hA3FF);
        read_expect("R11 word 1024",  16'd1024,  16'hB400);
        read_expect("R11 word 10239", 16'd10239, 16'h9FFF);
    endtask

    task automatic test_alias();
        read_expect("R5 read with bits 15:14 set", 16'd3079 | 16'hC000, 16'hC3D7);
        write_word(waddr(2, 7) | 16'h4000, 16'h2BBB);
        read_expect("R5 write alias lands low", waddr(2, 7), 16'h2BBB);
    endtask

    task automatic test_unmapped_write();
        write_word(waddr(8, 7), 16'h8888);
        write_word(waddr(7, 7), 16'h7777);
        write_word(waddr(10, 7), 16'hDEAD);
        write_word(waddr(15, 7), 16'hBEEF);
        read_expect("R6 bank0 kept",  waddr(0, 7), 16'h0007);
        read_expect("R6 bank2 kept",  waddr(2, 7), 16'h2BBB);
        read_expect("R6 bank3 kept",  waddr(3, 7), 16'hC3D7);
        read_expect("R6 bank7 kept",  waddr(7, 7), 16'h7777);
        read_expect("R6 bank8 kept",  waddr(8, 7), 16'h8888);
    endtask

    task automatic test_unmapped_read();
        read_expect("R7 prior valid read", waddr(8, 7), 16'h8888);
        read_expect("R7 bank field 10 reads zero", waddr(10, 7), 16'h0000);
        read_expect("R7 bank field 15 reads zero", waddr(15, 7) | 16'hC000, 16'h0000);
    endtask

    task automatic test_read_write();
        @(negedge clk);
        addr = 16'd1024; wr_data = 16'h1234; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R8 read returns old word", rd_data, 16'hB400);
        read_expect("R8 write stored", 16'd1024, 16'h1234);
    endtask

    task automatic test_latency();
        read_expect("R4 first read", 16'd0, 16'hA000);
        @(negedge clk);
        addr = 16'd1023; rd_en = 1'b1;
        #1;
        check("R4 unchanged before edge", rd_data, 16'hA000);
        @(negedge clk);
        rd_en = 1'b0;
        check("R4 valid after one edge", rd_data, 16'hA3FF);
    endtask

    task automatic test_hold();
        read_expect("R9 setup read", waddr(7, 7), 16'h7777);
        @(negedge clk);
        addr = 16'd10239;
        @(negedge clk);
        addr = waddr(12, 3); wr_data = 16'h5555; wr_en = 1'b1;
        @(negedge clk);
        addr = waddr(7, 7); wr_data = 16'h6666; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 output held without read", rd_data, 16'h7777);
        read_expect("R9 held-cycle write stored", waddr(7, 7), 16'h6666);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_split();
        test_edges();
        test_alias();
        test_unmapped_write();
        test_unmapped_read();
        test_read_write();
        test_latency();
        test_hold();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule